// File: doc/BRIEF.md
# Max-Log Soft-In Soft-Out Decoder

This block decodes one block of `N` trellis stages of a 4-state recursive systematic code. Each stage is one systematic and one parity output bit. Each stage supplies three signed integers: a systematic channel value, a parity channel value and an a priori log-likelihood ratio. Channel values arrive already scaled by the channel reliability. The block uses the max-log approximation: add-compare-select with a plain maximum and no correction term. After a block is loaded, a forward pass runs once over all stages and keeps every forward state-metric vector. A backward pass then walks the stages from last to first. On each step of that pass the block emits one soft output and its hard decision.

An upper iterative controller uses `app_mode` to choose the output type. In extrinsic mode the output holds only the information that the parity observations contribute. That is the value passed to the other constituent decoder. In a posteriori mode the output holds the full log-likelihood ratio, used on the final half-iteration. The a priori input is held at zero on the first half-iteration.

The controller has three states. `ST_LOAD` accepts stages. The transition *load done* moves to `ST_FWD` when the last stage is accepted. `ST_FWD` runs one forward step per cycle. The transition *forward done* moves to `ST_BWD` after stage `N-1`. `ST_BWD` runs one backward step per cycle and emits one output. The transition *block done* returns to `ST_LOAD` after stage 0.

Top module: `siso_maxlog`

## Requirements
- R1: In `ST_LOAD`, `in_ready` is 1 and the block accepts one stage on every cycle where `in_valid` is 1. Stages arrive in order 0 to `N-1`. `app_mode` is sampled only with stage 0, and later changes have no effect on that block.
- R2: When stage `N-1` is accepted, `in_ready` goes to 0 and stays 0 until the output for stage 0. The first output is visible exactly `N+1` clock cycles after the clock edge that accepted stage `N-1`.
- R3: The block gives exactly `N` outputs on consecutive cycles, with `out_idx` going from `N-1` down to 0. `in_ready` is 1 again in the same cycle as the output for stage 0, and `out_valid` is 0 on the next cycle unless a new block follows.
- R4: The trellis state is the value 2*d1+d0 of the two delay elements. For input bit u, the feedback bit is a = u^d1^d0, the parity bit is p = a^d0, and the next state is 2*a+d1. The branch metric is counted in units of half an input step. It equals +(apr+sys) when u=1 and -(apr+sys) when u=0, plus +par when p=1 and -par when p=0.
- R5: The forward metrics start at 0 for state 0 and -2^(MW-2) for states 1 to 3. Each next metric is the largest value of (previous metric + branch metric) over the two branches entering that state.
- R6: The backward metrics after the last stage start at 0 for all four states. Each backward metric is the largest value of (branch metric + next-stage backward metric) over the two branches leaving that state.
- R7: Every new forward or backward metric vector is first reduced by its own state-0 value. Each entry is then saturated to the signed `MW`-bit range.
- R8: When `app_mode`=1, `out_llr` is the largest alpha+gamma+beta over the four branches with u=1 minus the same maximum over the four branches with u=0. The result is exact and is not saturated.
- R9: When `app_mode`=0, the same two maxima use only the parity term of the branch metric. So for identical inputs, the a posteriori output minus the extrinsic output equals 2*(apr+sys) at every stage.
- R10: `out_bit` is 1 when `out_llr` is greater than 0, and 0 otherwise, including when `out_llr` is 0.
- R11: Take a block with no noise: stage values ±8 taken from the encoder defined in R4, starting in state 0, with apr=0. In a posteriori mode the hard decisions then equal the encoded information bits.
- R12: While `rst_n` is 0, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Stage values present |
| in_sys | input | IW | Systematic channel value, signed |
| in_par | input | IW | Parity channel value, signed |
| in_apr | input | IW | A priori LLR, signed |
| app_mode | input | 1 | 1 = a posteriori output, 0 = extrinsic output |
| in_ready | output | 1 | Block accepts stages |
| out_valid | output | 1 | Output stage valid |
| out_idx | output | KW | Stage index of the output |
| out_llr | output | LW | Output LLR, signed, half-step units |
| out_bit | output | 1 | Hard decision |

## Verification
Suppose a forward metric is stored wrong at stage k. The outputs for stages k and above are then wrong. Those stages come out first, so the fault shows on the first output cycles. A wrong backward metric shows from the next output onward, and it corrupts every lower stage. If the controller misses a count, the output index sequence breaks. It can also change the latency or raise `in_ready` too early, and each of these is visible within one cycle of the slip. The a posteriori-minus-extrinsic identity gives an exact check on each stage that does not depend on the recursion values.

// File: rtl/siso_pkg.sv
package siso_pkg;

    typedef enum logic [1:0] {
        ST_LOAD,
        ST_FWD,
        ST_BWD
    } siso_st_e;

    // state = {d1, d0}; feedback polynomial 1+D+D^2, forward 1+D^2
    function automatic logic [1:0] trel_next(input logic [1:0] s, input logic u);
        logic a;
        a = u ^ s[1] ^ s[0];
        return {a, s[1]};
    endfunction

    function automatic logic trel_par(input logic [1:0] s, input logic u);
        logic a;
        a = u ^ s[1] ^ s[0];
        return a ^ s[0];
    endfunction

endpackage

// File: rtl/siso_acs.sv
// One recursion step over the 4-state trellis, forward or backward variant.
module siso_acs
    import siso_pkg::*;
#(
    parameter int GW  = 8,
    parameter int MW  = 11,
    parameter bit FWD = 1'b1
) (
    input  logic [3:0][MW-1:0] m_in,
    input  logic [7:0][GW-1:0] gam,
    output logic [3:0][MW-1:0] m_out
);
    localparam int RW = MW + 2;
    localparam logic signed [RW-1:0] HI   = RW'((1 << (MW-1)) - 1);
    localparam logic signed [RW-1:0] LO   = RW'(-(1 << (MW-1)));
    localparam logic signed [RW-1:0] FLOOR = RW'(-(1 << (RW-1)));

    logic signed [RW-1:0] raw [4];

    generate
        if (FWD) begin : g_fwd
            always_comb begin
                logic [1:0] ns;
                logic signed [RW-1:0] c;
                for (int i = 0; i < 4; i++) raw[i] = FLOOR;
                for (int b = 0; b < 8; b++) begin
                    ns = trel_next(2'(b >> 1), b[0]);
                    c  = RW'($signed(m_in[2'(b >> 1)])) + RW'($signed(gam[b]));
                    if (c > raw[ns]) raw[ns] = c;
                end
            end
        end else begin : g_bwd
            always_comb begin
                logic [1:0] ns;
                logic signed [RW-1:0] c;
                for (int i = 0; i < 4; i++) raw[i] = FLOOR;
                for (int b = 0; b < 8; b++) begin
                    ns = trel_next(2'(b >> 1), b[0]);
                    c  = RW'($signed(m_in[ns])) + RW'($signed(gam[b]));
                    if (c > raw[b >> 1]) raw[b >> 1] = c;
                end
            end
        end
    endgenerate

    // normalise to state 0, then saturate
    always_comb begin
        logic signed [RW-1:0] d;
        for (int i = 0; i < 4; i++) begin
            d = raw[i] - raw[0];
            if (d > HI)      m_out[i] = MW'(HI);
            else if (d < LO) m_out[i] = MW'(LO);
            else             m_out[i] = MW'(d);
        end
    end
endmodule

// File: rtl/siso_llr.sv
// Combines forward, branch and backward metrics into one soft output.
module siso_llr
    import siso_pkg::*;
#(
    parameter int GW = 8,
    parameter int MW = 11,
    parameter int LW = MW + 3
) (
    input  logic [3:0][MW-1:0] alpha,
    input  logic [3:0][MW-1:0] beta,
    input  logic [7:0][GW-1:0] gam_full,
    input  logic [7:0][GW-1:0] gam_par,
    input  logic               app,
    output logic signed [LW-1:0] llr
);
    localparam logic signed [LW-1:0] FLOOR = LW'(-(1 << (LW-1)));

    always_comb begin
        logic [1:0] ns;
        logic signed [LW-1:0] t, g, max1, max0;
        max1 = FLOOR;
        max0 = FLOOR;
        for (int b = 0; b < 8; b++) begin
            ns = trel_next(2'(b >> 1), b[0]);
            g  = app ? LW'($signed(gam_full[b])) : LW'($signed(gam_par[b]));
            t  = LW'($signed(alpha[2'(b >> 1)])) + g + LW'($signed(beta[ns]));
            if (b[0]) begin
                if (t > max1) max1 = t;
            end else begin
                if (t > max0) max0 = t;
            end
        end
        llr = max1 - max0;
    end
endmodule

// File: rtl/siso_maxlog.sv
module siso_maxlog
    import siso_pkg::*;
#(
    parameter  int N  = 64,
    parameter  int IW = 6,
    parameter  int MW = 11,
    localparam int KW = $clog2(N),
    localparam int LW = MW + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [IW-1:0] in_sys,
    input  logic [IW-1:0] in_par,
    input  logic [IW-1:0] in_apr,
    input  logic          app_mode,
    output logic          in_ready,
    output logic          out_valid,
    output logic [KW-1:0] out_idx,
    output logic [LW-1:0] out_llr,
    output logic          out_bit
);
    localparam int GW = IW + 2;
    localparam int SW = IW + 1;
    localparam logic [KW-1:0] K_LAST = KW'(N - 1);
    localparam logic [MW-1:0] M_NEG  = MW'(-(1 << (MW - 2)));

    siso_st_e st, st_nx;
    logic [KW-1:0]       k;
    logic                mode_q;
    logic [3:0][MW-1:0]  alpha_q, beta_q, alpha_nx, beta_nx;
    logic signed [IW-1:0] sys_m [N];
    logic signed [IW-1:0] par_m [N];
    logic signed [IW-1:0] apr_m [N];
    logic [3:0][MW-1:0]  alp_m [N];
    logic [7:0][GW-1:0]  gam_full, gam_par;
    logic signed [SW-1:0] su;
    logic signed [LW-1:0] llr_w;
    logic acc, last_k;

    assign in_ready = (st == ST_LOAD);
    assign acc      = in_valid && (st == ST_LOAD);
    assign last_k   = (k == K_LAST);

    // ---------------- branch metrics of stage k ----------------
    assign su = SW'(sys_m[k]) + SW'(apr_m[k]);

    generate
        for (genvar b = 0; b < 8; b++) begin : g_br
            localparam logic [1:0] BS = 2'(b >> 1);
            localparam logic       BU = ((b % 2) == 1);
            localparam logic       BP = trel_par(BS, BU);
            logic signed [GW-1:0] ts, tp;
            assign ts = BU ? GW'(su) : -GW'(su);
            assign tp = BP ? GW'(par_m[k]) : -GW'(par_m[k]);
            assign gam_full[b] = ts + tp;
            assign gam_par[b]  = tp;
        end
    endgenerate

    siso_acs #(.GW(GW), .MW(MW), .FWD(1'b1)) u_fwd (
        .m_in(alpha_q), .gam(gam_full), .m_out(alpha_nx));

    siso_acs #(.GW(GW), .MW(MW), .FWD(1'b0)) u_bwd (
        .m_in(beta_q), .gam(gam_full), .m_out(beta_nx));

    siso_llr #(.GW(GW), .MW(MW), .LW(LW)) u_llr (
        .alpha(alp_m[k]), .beta(beta_q), .gam_full(gam_full),
        .gam_par(gam_par), .app(mode_q), .llr(llr_w));

    // ---------------- controller ----------------
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_LOAD: if (acc && last_k) st_nx = ST_FWD;
            ST_FWD:  if (last_k)        st_nx = ST_BWD;
            ST_BWD:  if (k == '0)       st_nx = ST_LOAD;
            default:                    st_nx = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_LOAD;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k       <= '0;
            mode_q  <= 1'b0;
            alpha_q <= '0;
            beta_q  <= '0;
        end else begin
            unique case (st)
                ST_LOAD: if (acc) begin
                    if (k == '0) mode_q <= app_mode;
                    if (last_k) begin
                        k       <= '0;
                        alpha_q <= {M_NEG, M_NEG, M_NEG, MW'(0)};
                    end else begin
                        k <= k + KW'(1);
                    end
                end
                ST_FWD: begin
                    alpha_q <= alpha_nx;
                    if (last_k) beta_q <= '0;
                    else        k      <= k + KW'(1);
                end
                ST_BWD: begin
                    beta_q <= beta_nx;
                    if (k != '0) k <= k - KW'(1);
                end
                default: k <= '0;
            endcase
        end
    end

    // stage storage, no reset needed
    always_ff @(posedge clk) begin
        if (acc) begin
            sys_m[k] <= $signed(in_sys);
            par_m[k] <= $signed(in_par);
            apr_m[k] <= $signed(in_apr);
        end
        if (st == ST_FWD) alp_m[k] <= alpha_q;
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_idx   <= '0;
            out_llr   <= '0;
            out_bit   <= 1'b0;
        end else begin
            out_valid <= (st == ST_BWD);
            out_idx   <= k;
            out_llr   <= llr_w;
            out_bit   <= (llr_w > 0);
        end
    end
endmodule

// File: rtl/siso_maxlog_chk.sv
module siso_maxlog_chk #(
    parameter  int N  = 64,
    localparam int KW = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic [KW-1:0] out_idx
);
    logic [KW:0] acc_cnt;
    logic        acc, fin;
    assign acc = in_valid && in_ready;
    assign fin = out_valid && (out_idx == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   acc_cnt <= '0;
        else if (fin) acc_cnt <= acc ? (KW+1)'(1) : '0;
        else if (acc) acc_cnt <= acc_cnt + (KW+1)'(1);
    end

    // R1: no more than N stages accepted per block
    a_r1_load_window: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !fin) |-> (acc_cnt < (KW+1)'(N)));

    // R2: no input accepted while the block is still emitting
    a_r2_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_idx != '0) |-> !in_ready);

    // R3: first output is the last stage
    a_r3_first_top: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_idx == KW'(N - 1)));

    // R3: indices fall by one on consecutive outputs
    a_r3_descend: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid) && $past(out_idx) != '0)
            |-> (out_idx == KW'($past(out_idx) - KW'(1))));

    // R3: stage 0 releases the input side and ends the burst
    a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> in_ready);

    a_r3_burst_end: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !acc) |=> !out_valid);
endmodule

bind siso_maxlog siso_maxlog_chk #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_idx(out_idx));

// File: tb/siso_maxlog_tb.sv
`timescale 1ns/1ps
module siso_maxlog_tb;
    localparam int N  = 64;
    localparam int IW = 6;
    localparam int MW = 11;
    localparam int KW = $clog2(N);
    localparam int LW = MW + 3;
    localparam int HI = (1 << (MW-1)) - 1;
    localparam int LO = -(1 << (MW-1));
    localparam int NEG = -(1 << (MW-2));

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, in_valid, app_mode;
    logic [IW-1:0] in_sys, in_par, in_apr;
    logic in_ready, out_valid, out_bit;
    logic [KW-1:0] out_idx;
    logic [LW-1:0] out_llr;

    siso_maxlog u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sys(in_sys),
        .in_par(in_par), .in_apr(in_apr), .app_mode(app_mode),
        .in_ready(in_ready), .out_valid(out_valid), .out_idx(out_idx),
        .out_llr(out_llr), .out_bit(out_bit));

    int ys[N], yp[N], ya[N], ex[N], gl[N], ext_keep[N], info[N];
    int n_cmp = 0, n_bad = 0, cyc = 0;
    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R4 trellis
    function automatic int f_nxt(input int s, input int u);
        int a = u ^ (s >> 1) ^ (s & 1);
        return a * 2 + (s >> 1);
    endfunction
    function automatic int f_par(input int s, input int u);
        int a = u ^ (s >> 1) ^ (s & 1);
        return a ^ (s & 1);
    endfunction
    function automatic int f_sat(input int v);
        if (v > HI) return HI;
        if (v < LO) return LO;
        return v;
    endfunction
    function automatic int f_gam(input int k, input int s, input int u, input int full);
        int su = ya[k] + ys[k];
        int g  = f_par(s, u) ? yp[k] : -yp[k];
        if (full != 0) g += u ? su : -su;
        return g;
    endfunction

    // R5 R6 R7 R8 R9 reference
    function automatic void ref_decode(input int md);
        int al[N][4];
        int a[4], bt[4], raw[4], r0, c, m1, m0;
        a = '{0, NEG, NEG, NEG};
        for (int k = 0; k < N; k++) begin
            al[k] = a;
            raw = '{-100000, -100000, -100000, -100000};
            for (int b = 0; b < 8; b++) begin
                c = a[b/2] + f_gam(k, b/2, b%2, 1);
                if (c > raw[f_nxt(b/2, b%2)]) raw[f_nxt(b/2, b%2)] = c;
            end
            r0 = raw[0];
            for (int i = 0; i < 4; i++) a[i] = f_sat(raw[i] - r0);
        end
        bt = '{0, 0, 0, 0};
        for (int k = N-1; k >= 0; k--) begin
            m1 = -100000; m0 = -100000;
            raw = '{-100000, -100000, -100000, -100000};
            for (int b = 0; b < 8; b++) begin
                c = al[k][b/2] + f_gam(k, b/2, b%2, md) + bt[f_nxt(b/2, b%2)];
                if (b % 2 == 1) begin if (c > m1) m1 = c; end
                else            begin if (c > m0) m0 = c; end
                c = f_gam(k, b/2, b%2, 1) + bt[f_nxt(b/2, b%2)];
                if (c > raw[b/2]) raw[b/2] = c;
            end
            ex[k] = m1 - m0;
            r0 = raw[0];
            for (int i = 0; i < 4; i++) bt[i] = f_sat(raw[i] - r0);
        end
    endfunction

    // starts and ends on a falling edge
    task automatic run_block(input int md);
        int t_acc, got, tmo, idx, v;
        ref_decode(md);
        for (int i = 0; i < N; i++) begin
            if ($urandom_range(3, 0) == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            chk(in_ready == 1'b1, "R1 in_ready during load", int'(in_ready), 1);
            in_valid = 1'b1;
            in_sys   = IW'(ys[i]);
            in_par   = IW'(yp[i]);
            in_apr   = IW'(ya[i]);
            app_mode = (i == 0) ? md[0] : ~md[0];   // R1: later mode changes ignored
            @(negedge clk);
        end
        in_valid = 1'b0;
        app_mode = ~md[0];
        t_acc = cyc;
        got = 0; tmo = 0;
        while (got < N && tmo < 4 * N) begin
            if (out_valid) begin
                idx = int'(out_idx);
                v   = int'($signed(out_llr));
                if (got == 0)
                    chk(cyc - t_acc == N + 1, "R2 latency", cyc - t_acc, N + 1);
                chk(idx == N - 1 - got, "R3 order", idx, N - 1 - got);
                chk(v == ex[idx], md ? "R8 app llr (R1 R4 R5 R6 R7)" : "R9 ext llr (R1 R4 R5 R6 R7)",
                    v, ex[idx]);
                chk(int'(out_bit) == ((ex[idx] > 0) ? 1 : 0), "R10 hard decision",
                    int'(out_bit), (ex[idx] > 0) ? 1 : 0);
                if (idx != 0) chk(in_ready == 1'b0, "R2 in_ready low", int'(in_ready), 0);
                else          chk(in_ready == 1'b1, "R3 release", int'(in_ready), 1);
                gl[idx] = v;
                got++;
            end else if (got > 0) begin
                chk(1'b0, "R3 gap in output burst", 0, 1);
                got = N;
            end
            if (got < N) begin
                @(negedge clk);
                tmo++;
            end
        end
        if (got < N) chk(1'b0, "R2 output timeout", got, N);
        @(negedge clk);
        chk(out_valid == 1'b0, "R3 burst ended", int'(out_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int st;
        void'($urandom(32'd5071));
        rst_n = 1'b0; in_valid = 1'b0; app_mode = 1'b0;
        in_sys = '0; in_par = '0; in_apr = '0;
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1, "R12 reset in_ready", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R12 reset out_valid", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // all-zero block: every LLR 0, decision 0 (R10)
        for (int i = 0; i < N; i++) begin ys[i] = 0; yp[i] = 0; ya[i] = 0; end
        run_block(1);
        run_block(0);

        // noiseless codeword (R11)
        st = 0;
        for (int i = 0; i < N; i++) begin
            info[i] = int'($urandom_range(1, 0));
            ys[i] = info[i] ? 8 : -8;
            yp[i] = f_par(st, info[i]) ? 8 : -8;
            ya[i] = 0;
            st = f_nxt(st, info[i]);
        end
        run_block(1);
        for (int i = 0; i < N; i++)
            chk(((gl[i] > 0) ? 1 : 0) == info[i], "R11 noiseless decode",
                (gl[i] > 0) ? 1 : 0, info[i]);

        // extreme values, saturation stress (R7)
        for (int i = 0; i < N; i++) begin
            ys[i] = (i % 3 == 0) ? 31 : -32;
            yp[i] = (i % 2 == 1) ? 31 : -32;
            ya[i] = (i % 5 == 0) ? -32 : 31;
        end
        run_block(1);
        run_block(0);

        // random blocks in both modes, identity of R9
        for (int r = 0; r < 5; r++) begin
            for (int i = 0; i < N; i++) begin
                ys[i] = int'($urandom_range(63, 0)) - 32;
                yp[i] = int'($urandom_range(63, 0)) - 32;
                ya[i] = (r == 0) ? 0 : int'($urandom_range(63, 0)) - 32;
            end
            run_block(0);
            for (int i = 0; i < N; i++) ext_keep[i] = gl[i];
            run_block(1);
            for (int i = 0; i < N; i++)
                chk(gl[i] - ext_keep[i] == 2 * (ya[i] + ys[i]), "R9 app minus ext",
                    gl[i] - ext_keep[i], 2 * (ya[i] + ys[i]));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule